// File: doc/BRIEF.md
# 2D Drawing Engine Status and Background Color Registers

This block is the register slice of a 2D drawing engine that a host sees over a simple request bus. It holds two word registers. The first stores a background color, and its read path adapts to the current pixel depth. The second is a read-only status word built from the engine's activity signals: blit and line activity, host FIFO level flags, and the interrupt request. It also carries a combined busy indication and its complement.

Busy has two definitions, chosen by a configuration input. In fine-grained mode, busy is high whenever any unit of the engine does work. In per-operation mode, a sticky flag is set when an operation starts. The flag is released only once the operation has ended, memory writes have drained and the host FIFO is empty, all in the same cycle. The drawing engine, the FIFO storage and the memory path lie outside the block and appear only as inputs.

Every bus request is acknowledged one cycle later. A read returns its data in that same cycle, marked by a valid strobe.

Top module: `gfx_stat_regs`

## Requirements
- R1: A status read returns these bits: bit 0 is blit active, bit 1 is line active, bit 2 is FIFO full, bit 3 is FIFO not empty, bit 8 is busy, bit 9 is done and bit 10 is interrupt. All other bits are 0. The values are sampled at the clock edge that accepts the read.
- R2: The done bit (bit 9) of every status read is the inverse of the busy bit (bit 8).
- R3: With `fine_busy_i`=1, busy is the OR of `reg_acc_i`, `fifo_nempty_i`, `blit_act_i`, `line_act_i` and `wr_pend_i`.
- R4: With `fine_busy_i`=0, busy is a flag that is set the cycle after `op_start_i`. It is cleared the cycle after `op_done_i`=1, `wr_pend_i`=0 and `fifo_nempty_i`=0 hold together. If a start occurs in that same cycle, the set wins. After reset the flag is 0.
- R5: A write to the status offset (1) changes no register, and it is acknowledged like any other write.
- R6: Each cycle with `req_i`=1 is followed by exactly one cycle with `ack_o`=1. No acknowledge appears without a request.
- R7: `rvalid_o` is 1 exactly in the cycle after a read request, and `rdata_o` holds the read data in that cycle. After reset, `ack_o`, `rvalid_o` and `rdata_o` are 0.
- R8: With `depth_i`=0 (8 bpp), a color read returns the low byte in all four byte lanes.
- R9: With `depth_i`=1 (16 bpp), a color read returns the low halfword in both halves.
- R10: With `depth_i`=2 (32 bpp) or 3, a color read returns all 32 stored bits.
- R11: The color register (offset 0) stores all 32 written bits at every depth. Only a host write to offset 0 changes it. After reset it is 0.
- R12: The interrupt bit is the live `irq_i` input at the read edge.
- R13: Reads of offsets 2 and 3 return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word offset: 0 color, 1 status |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access acknowledge, one cycle after request |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| depth_i | input | 2 | Pixel depth: 0 8 bpp, 1 16 bpp, 2/3 32 bpp |
| fine_busy_i | input | 1 | Busy definition: 1 fine-grained, 0 per operation |
| reg_acc_i | input | 1 | Register access in progress |
| fifo_full_i | input | 1 | Host FIFO full |
| fifo_nempty_i | input | 1 | Host FIFO not empty |
| blit_act_i | input | 1 | Blit in progress |
| line_act_i | input | 1 | Line draw in progress |
| wr_pend_i | input | 1 | Memory writes outstanding |
| op_start_i | input | 1 | Operation start pulse |
| op_done_i | input | 1 | Operation finished |
| irq_i | input | 1 | Engine interrupt request |

## Verification
The assertions assume a synchronous host that presents each request for one cycle, with stable address and direction. They assume no constraint on the activity inputs, which may change in any cycle and in any combination, including a start and a release condition in the same cycle. The stimulus drives every input at the falling edge. It mixes directed sequences with unconstrained random activity and random accesses, so the set-over-clear case and the depth changes between write and read both occur.

// File: rtl/gfx_stat_pkg.sv
`timescale 1ns/1ps
package gfx_stat_pkg;
  typedef enum logic [1:0] {
    DEPTH_8   = 2'd0,
    DEPTH_16  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_RSV = 2'd3
  } depth_e;

  localparam int unsigned ST_BLIT   = 0;
  localparam int unsigned ST_LINE   = 1;
  localparam int unsigned ST_FULL   = 2;
  localparam int unsigned ST_NEMPTY = 3;
  localparam int unsigned ST_BUSY   = 8;
  localparam int unsigned ST_DONE   = 9;
  localparam int unsigned ST_IRQ    = 10;
endpackage

// File: rtl/gfx_color_reg.sv
`timescale 1ns/1ps
module gfx_color_reg
  import gfx_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  depth_e            depth_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int unsigned N_BYTES = DATA_W / 8;
  localparam int unsigned N_HALF  = DATA_W / 16;

  logic [DATA_W-1:0] color_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      color_q <= '0;
    else if (wr_en_i) color_q <= wdata_i;
  end

  // replication only on the read path; storage is always full width
  always_comb begin
    rd_o = color_q;
    unique case (depth_i)
      DEPTH_8:  for (int i = 0; i < N_BYTES; i++) rd_o[i*8 +: 8]  = color_q[7:0];
      DEPTH_16: for (int i = 0; i < N_HALF; i++)  rd_o[i*16 +: 16] = color_q[15:0];
      default:  rd_o = color_q;
    endcase
  end

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(color_q));
  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> color_q == $past(wdata_i));
endmodule

// File: rtl/gfx_busy_track.sv
`timescale 1ns/1ps
module gfx_busy_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fine_i,
  input  logic reg_acc_i,
  input  logic fifo_nempty_i,
  input  logic blit_i,
  input  logic line_i,
  input  logic wr_pend_i,
  input  logic op_start_i,
  input  logic op_done_i,
  output logic busy_o
);
  logic op_flag_q;
  logic release_c;
  logic fine_busy_c;

  assign release_c   = op_done_i && !wr_pend_i && !fifo_nempty_i;
  assign fine_busy_c = reg_acc_i | fifo_nempty_i | blit_i | line_i | wr_pend_i;

  // start has priority over release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         op_flag_q <= 1'b0;
    else if (op_start_i) op_flag_q <= 1'b1;
    else if (release_c)  op_flag_q <= 1'b0;
  end

  assign busy_o = fine_i ? fine_busy_c : op_flag_q;

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i |=> op_flag_q);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_flag_q && !(op_done_i && !wr_pend_i && !fifo_nempty_i)) |=> op_flag_q);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_start_i && op_done_i && !wr_pend_i && !fifo_nempty_i) |=> !op_flag_q);
  p_fine_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_i && (blit_i || line_i || wr_pend_i)) |-> busy_o);
endmodule

// File: rtl/gfx_stat_regs.sv
`timescale 1ns/1ps
module gfx_stat_regs
  import gfx_stat_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned COLOR_OFS  = 0,
  parameter int unsigned STATUS_OFS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        depth_i,
  input  logic              fine_busy_i,
  input  logic              reg_acc_i,
  input  logic              fifo_full_i,
  input  logic              fifo_nempty_i,
  input  logic              blit_act_i,
  input  logic              line_act_i,
  input  logic              wr_pend_i,
  input  logic              op_start_i,
  input  logic              op_done_i,
  input  logic              irq_i
);
  localparam logic [ADDR_W-1:0] COLOR_A  = ADDR_W'(COLOR_OFS);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

  logic              sel_color, sel_status, rd_req;
  logic              busy;
  logic [DATA_W-1:0] color_rd, status_word, rd_mux;
  logic              ack_q, rvalid_q, stat_rd_q;
  logic [DATA_W-1:0] rdata_q;

  assign sel_color  = addr_i == COLOR_A;
  assign sel_status = addr_i == STATUS_A;
  assign rd_req     = req_i && !we_i;

  gfx_color_reg #(.DATA_W(DATA_W)) i_color (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (req_i && we_i && sel_color),
    .wdata_i (wdata_i),
    .depth_i (depth_e'(depth_i)),
    .rd_o    (color_rd)
  );

  gfx_busy_track i_busy (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fine_i        (fine_busy_i),
    .reg_acc_i     (reg_acc_i),
    .fifo_nempty_i (fifo_nempty_i),
    .blit_i        (blit_act_i),
    .line_i        (line_act_i),
    .wr_pend_i     (wr_pend_i),
    .op_start_i    (op_start_i),
    .op_done_i     (op_done_i),
    .busy_o        (busy)
  );

  always_comb begin
    status_word            = '0;
    status_word[ST_BLIT]   = blit_act_i;
    status_word[ST_LINE]   = line_act_i;
    status_word[ST_FULL]   = fifo_full_i;
    status_word[ST_NEMPTY] = fifo_nempty_i;
    status_word[ST_BUSY]   = busy;
    status_word[ST_DONE]   = !busy;
    status_word[ST_IRQ]    = irq_i;
  end

  always_comb begin
    if (sel_color)       rd_mux = color_rd;
    else if (sel_status) rd_mux = status_word;
    else                 rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q     <= 1'b0;
      rvalid_q  <= 1'b0;
      stat_rd_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ack_q     <= req_i;
      rvalid_q  <= rd_req;
      stat_rd_q <= rd_req && sel_status;
      if (rd_req) rdata_q <= rd_mux;
    end
  end

  assign ack_o    = ack_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  p_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  p_no_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  p_rvalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  p_no_rvalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
  p_done_inv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && stat_rd_q) |-> (rdata_o[ST_DONE] != rdata_o[ST_BUSY]));
  p_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel_status) |=> rdata_o[ST_IRQ] == $past(irq_i));
  p_unmapped_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !sel_color && !sel_status) |=> rdata_o == '0);
endmodule

// File: tb/test_gfx_stat_regs.sv
`timescale 1ns/1ps
module test_gfx_stat_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        ack, rvalid;
  logic [31:0] rdata;
  logic [1:0]  depth = 2;
  logic        fine = 1, racc = 0, full = 0, nempty = 0, blit = 0, line = 0;
  logic        wrp = 0, start = 0, done = 0, irq = 0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_color = 0;
  bit          m_flag = 0;

  always #5 clk = ~clk;

  gfx_stat_regs i_gfx_stat_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rvalid_o(rvalid), .rdata_o(rdata),
    .depth_i(depth), .fine_busy_i(fine), .reg_acc_i(racc), .fifo_full_i(full),
    .fifo_nempty_i(nempty), .blit_act_i(blit), .line_act_i(line),
    .wr_pend_i(wrp), .op_start_i(start), .op_done_i(done), .irq_i(irq)
  );

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: predict, advance model, compare after the edge
  task automatic step(string tag);
    logic [31:0] e_rd, st;
    bit e_ack, e_rv, busy;
    busy = fine ? (racc | nempty | blit | line | wrp) : m_flag;
    st = 32'h0;
    st[0] = blit; st[1] = line; st[2] = full; st[3] = nempty;
    st[8] = busy; st[9] = !busy; st[10] = irq;
    case (addr)
      2'd0: case (depth)
              2'd0: e_rd = {4{m_color[7:0]}};
              2'd1: e_rd = {2{m_color[15:0]}};
              default: e_rd = m_color;
            endcase
      2'd1: e_rd = st;
      default: e_rd = 32'h0;
    endcase
    e_ack = req;
    e_rv  = req && !we;
    @(posedge clk);
    if (req && we && addr == 2'd0) m_color = wdata;
    if (start) m_flag = 1;
    else if (done && !wrp && !nempty) m_flag = 0;
    #1;
    cmp("R6 ack", 32'(ack), 32'(e_ack));
    cmp("R7 rvalid", 32'(rvalid), 32'(e_rv));
    if (e_rv) cmp(tag, rdata, e_rd);
    @(negedge clk);
    req = 0; we = 0; start = 0;
  endtask

  task automatic rd(logic [1:0] a, string tag);
    req = 1; we = 0; addr = a; step(tag);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
    req = 1; we = 1; addr = a; wdata = d; step(tag);
  endtask

  task automatic clr_act();
    racc = 0; full = 0; nempty = 0; blit = 0; line = 0; wrp = 0; done = 0; irq = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #22;
    // R7 reset state
    cmp("R7 reset ack", 32'(ack), 0);
    cmp("R7 reset rvalid", 32'(rvalid), 0);
    cmp("R7 reset rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, "R11 color after reset");

    // color depths: R8 R9 R10 R11
    depth = 2; wr(2'd0, 32'hA1B2C3D4, "R11 write");
    rd(2'd0, "R10 32bpp");
    depth = 0; rd(2'd0, "R8 8bpp");
    depth = 1; rd(2'd0, "R9 16bpp");
    depth = 3; rd(2'd0, "R10 depth3");
    depth = 0; wr(2'd0, 32'h12345678, "R11 full store at 8bpp");
    depth = 2; rd(2'd0, "R11 all bits kept");

    // status write ignored R5, unmapped R13
    wr(2'd1, 32'hFFFFFFFF, "R5 status write");
    rd(2'd0, "R5 color unchanged");
    rd(2'd1, "R5 status unchanged");
    wr(2'd2, 32'h0BADF00D, "R13 write ignored");
    wr(2'd3, 32'h0BADF00D, "R13 write ignored");
    rd(2'd0, "R13 color unchanged");
    blit = 1; irq = 1;
    rd(2'd2, "R13 read zero");
    rd(2'd3, "R13 read zero");
    clr_act();

    // fine-grained busy R3 R1 R2
    fine = 1;
    rd(2'd1, "R3 idle");
    racc = 1;   rd(2'd1, "R3 reg access"); racc = 0;
    nempty = 1; rd(2'd1, "R3 fifo nempty"); nempty = 0;
    blit = 1;   rd(2'd1, "R1 blit"); blit = 0;
    line = 1;   rd(2'd1, "R1 line"); line = 0;
    wrp = 1;    rd(2'd1, "R3 wr pend"); wrp = 0;
    full = 1;   rd(2'd1, "R1 full alone"); full = 0;
    irq = 1;    rd(2'd1, "R12 irq high");
    irq = 0;    rd(2'd1, "R12 irq low");
    blit = 1; line = 1; full = 1; nempty = 1; irq = 1;
    rd(2'd1, "R2 all set");
    clr_act();

    // per-operation busy R4
    fine = 0;
    rd(2'd1, "R4 idle after reset");
    start = 1; step("R4 start");
    rd(2'd1, "R4 set");
    done = 1; wrp = 1; rd(2'd1, "R4 hold wr pend");
    wrp = 0; nempty = 1; rd(2'd1, "R4 hold fifo");
    nempty = 0; done = 0; rd(2'd1, "R4 hold not done");
    done = 1; step("R4 release");
    done = 0; rd(2'd1, "R4 cleared");
    start = 1; done = 1; step("R4 set wins");
    done = 0; rd(2'd1, "R4 set over clear");
    fine = 1; rd(2'd1, "R3 mode switch");
    clr_act();

    // random mix
    for (int i = 0; i < 2000; i++) begin
      automatic logic [31:0] r = $urandom;
      fine = r[0]; racc = r[1]; full = r[2]; nempty = r[3]; blit = r[4];
      line = r[5]; wrp = r[6]; start = r[7] & r[8]; done = r[9]; irq = r[10];
      depth = r[12:11]; req = r[13]; we = r[14] & r[15]; addr = r[17:16];
      wdata = $urandom;
      step(addr == 2'd1 ? "R1 R2 random status" : "R11 random color");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule